// File: doc/BRIEF.md
# Widening Quad-Lane Multiply-Subtract Row Unit

This block updates one accumulator row per operation. Each operation brings two source vector words and one accumulator vector word, all `VL` bits wide, a size control and a 2-bit row select. For every wide accumulator lane, the block takes one narrow unsigned element from each source and multiplies them. It subtracts the product from the lane and returns the updated row one clock later with a valid strobe.

The size control picks the lane format. With `in_sz = 0` the lanes are 32 bits wide and the sources are 8-bit elements. With `in_sz = 1` the lanes are 64 bits wide and the sources are 16-bit elements. Each lane's four narrow source elements sit inside the lane's own bit span, and the row select picks one of those four. A caller that updates four consecutive accumulator rows issues four operations with row select 0 to 3.

The 64-bit format can be left out at build time with `WIDE_EN = 0`. A request for it then comes back flagged as undefined, with the accumulator returned unchanged.

A small controller sequences the result. Its state is named in the tables below.

| State | Meaning |
|---|---|
| `ST_IDLE` | no result this cycle |
| `ST_RESULT` | a computed row is on `out_acc` |
| `ST_REJECT` | an unsupported request was refused; `out_acc` holds the input row |

| Transition | Condition |
|---|---|
| any → `ST_RESULT` | `in_valid` with a supported size |
| any → `ST_REJECT` | `in_valid` with `in_sz = 1` and `WIDE_EN = 0` |
| any → `ST_IDLE` | no `in_valid` |

Top module: `quad_msub_row`

## Requirements
- R1: With `in_sz = 0`, the row is treated as `VL/32` lanes of 32 bits, each fed by 8-bit source elements. With `in_sz = 1`, it is treated as `VL/64` lanes of 64 bits, each fed by 16-bit source elements.
- R2: For lane `e` and row select `i`, both source operands are the unsigned narrow element of index `4*e+i`. With `N` the narrow width, that element occupies bits `[(4*e+i)*N +: N]` of `in_src_a` and of `in_src_b`.
- R3: The new lane value is the old lane value minus the zero-extended product, modulo 2 to the power of the lane width. When both operands are all-ones, the lane wraps around.
- R4: Every lane of the row is written on every accepted operation; there is no per-lane enable.
- R5: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise.
- R6: When `WIDE_EN = 0` and an operation has `in_sz = 1`, the next cycle shows `out_valid` and `out_undef` high and `out_acc` equal to the input `in_acc`.
- R7: `out_undef` is low for every supported operation and whenever `out_valid` is low.
- R8: During and right after reset, `out_valid`, `out_undef` and `out_acc` are all zero.
- R9: Operations on consecutive cycles each produce their own result on consecutive cycles, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| in_valid | input | 1 | operation present this cycle |
| in_sz | input | 1 | 0: 32-bit lanes / 8-bit sources; 1: 64-bit lanes / 16-bit sources |
| in_row | input | 2 | row select `i`, picks narrow element `4*e+i` |
| in_src_a | input | VL | first source vector |
| in_src_b | input | VL | second source vector |
| in_acc | input | VL | accumulator row before the update |
| out_valid | output | 1 | result present |
| out_undef | output | 1 | operation refused as unsupported |
| out_acc | output | VL | updated accumulator row |

## Verification
The assertions check the cycle-level contract on every cycle. They cover the one-cycle valid latency and the qualification of the undefined flag. They also check two content rules: a refused operation passes the row through, and a zero second source leaves the row unchanged. Only the bench's scenarios can show the arithmetic itself. That covers choosing element `4*e+i` in both sizes and for every row select, subtracting with wraparound on all-ones operands, and updating every lane. The bench compares each result against a per-lane reference loop, running a full-featured instance and one built without the wide format.

// File: rtl/quad_msub_pkg.sv
package quad_msub_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_REJECT = 2'd2
    } msub_state_t;

    localparam int unsigned NARROW_LANE_W = 32;
    localparam int unsigned WIDE_LANE_W   = 64;
    localparam int unsigned ROWS_PER_LANE = 4;

endpackage

// File: rtl/msub_lane.sv
module msub_lane #(
    parameter int unsigned ACC_W = 32
) (
    input  logic [1:0]       row,
    input  logic [ACC_W-1:0] src_a,
    input  logic [ACC_W-1:0] src_b,
    input  logic [ACC_W-1:0] acc,
    output logic [ACC_W-1:0] res
);
    localparam int unsigned NW    = ACC_W / quad_msub_pkg::ROWS_PER_LANE;
    localparam int unsigned PW    = 2 * NW;
    localparam int unsigned PAD_W = ACC_W - PW;

    logic [NW-1:0] op_a;
    logic [NW-1:0] op_b;
    logic [PW-1:0] prod;

    always_comb begin
        op_a = src_a[row*NW +: NW];
        op_b = src_b[row*NW +: NW];
        prod = op_a * op_b;
        res  = acc - {{PAD_W{1'b0}}, prod};
    end
endmodule

// File: rtl/msub_ctrl.sv
module msub_ctrl
    import quad_msub_pkg::*;
#(
    parameter bit WIDE_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sz,
    output logic legal,
    output logic res_valid,
    output logic res_undef
);
    msub_state_t state_q, state_d;

    always_comb begin
        legal = !in_sz || WIDE_EN;
        if (!in_valid)  state_d = ST_IDLE;
        else if (legal) state_d = ST_RESULT;
        else            state_d = ST_REJECT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        res_valid = 1'b0;
        res_undef = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RESULT: res_valid = 1'b1;
            ST_REJECT: begin
                res_valid = 1'b1;
                res_undef = 1'b1;
            end
            default:   ;
        endcase
    end
endmodule

// File: rtl/quad_msub_row.sv
module quad_msub_row
    import quad_msub_pkg::*;
#(
    parameter int unsigned VL      = 128,
    parameter bit          WIDE_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sz,
    input  logic [1:0]    in_row,
    input  logic [VL-1:0] in_src_a,
    input  logic [VL-1:0] in_src_b,
    input  logic [VL-1:0] in_acc,
    output logic          out_valid,
    output logic          out_undef,
    output logic [VL-1:0] out_acc
);
    localparam int unsigned N_NARROW = VL / NARROW_LANE_W;
    localparam int unsigned N_WIDE   = VL / WIDE_LANE_W;

    logic          legal;
    logic [VL-1:0] row_narrow;
    logic [VL-1:0] row_wide;
    logic [VL-1:0] row_next;

    msub_ctrl #(.WIDE_EN(WIDE_EN)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sz     (in_sz),
        .legal     (legal),
        .res_valid (out_valid),
        .res_undef (out_undef)
    );

    for (genvar e = 0; e < N_NARROW; e++) begin : g_narrow
        msub_lane #(.ACC_W(NARROW_LANE_W)) u_lane (
            .row   (in_row),
            .src_a (in_src_a[e*NARROW_LANE_W +: NARROW_LANE_W]),
            .src_b (in_src_b[e*NARROW_LANE_W +: NARROW_LANE_W]),
            .acc   (in_acc[e*NARROW_LANE_W +: NARROW_LANE_W]),
            .res   (row_narrow[e*NARROW_LANE_W +: NARROW_LANE_W])
        );
    end

    if (WIDE_EN) begin : g_wide_on
        for (genvar e = 0; e < N_WIDE; e++) begin : g_wide
            msub_lane #(.ACC_W(WIDE_LANE_W)) u_lane (
                .row   (in_row),
                .src_a (in_src_a[e*WIDE_LANE_W +: WIDE_LANE_W]),
                .src_b (in_src_b[e*WIDE_LANE_W +: WIDE_LANE_W]),
                .acc   (in_acc[e*WIDE_LANE_W +: WIDE_LANE_W]),
                .res   (row_wide[e*WIDE_LANE_W +: WIDE_LANE_W])
            );
        end
    end else begin : g_wide_off
        assign row_wide = in_acc;
    end

    always_comb begin
        if (!legal)     row_next = in_acc;
        else if (in_sz) row_next = row_wide;
        else            row_next = row_narrow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_acc <= '0;
        else if (in_valid) out_acc <= row_next;
    end
endmodule

// File: rtl/quad_msub_row_chk.sv
module quad_msub_row_chk #(
    parameter int unsigned VL      = 128,
    parameter bit          WIDE_EN = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_sz,
    input logic [VL-1:0] in_src_b,
    input logic [VL-1:0] in_acc,
    input logic          out_valid,
    input logic          out_undef,
    input logic [VL-1:0] out_acc
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R5
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R5
    AST_UNDEF_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> out_valid); // R7
    AST_UNDEF_ONLY_UNSUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (!in_sz || WIDE_EN) |=> !out_undef); // R7
    AST_REJECT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_sz && !WIDE_EN |=> out_undef); // R6
    AST_REJECT_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_sz && !WIDE_EN |=> out_acc == $past(in_acc)); // R6
    AST_ZERO_PRODUCT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_src_b == '0 |=> out_acc == $past(in_acc)); // R3
endmodule

bind quad_msub_row quad_msub_row_chk #(.VL(VL), .WIDE_EN(WIDE_EN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sz     (in_sz),
    .in_src_b  (in_src_b),
    .in_acc    (in_acc),
    .out_valid (out_valid),
    .out_undef (out_undef),
    .out_acc   (out_acc)
);

// File: tb/test_quad_msub_row.sv
module test_quad_msub_row;
    localparam int unsigned VL = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sz = 1'b0;
    logic [1:0]    in_row = 2'd0;
    logic [VL-1:0] in_src_a = '0;
    logic [VL-1:0] in_src_b = '0;
    logic [VL-1:0] in_acc = '0;
    logic          f_valid, f_undef, n_valid, n_undef;
    logic [VL-1:0] f_acc, n_acc;

    int checks = 0;
    int errors = 0;
    bit exp_v = 1'b0;
    bit exp_fu = 1'b0;
    bit exp_nu = 1'b0;
    logic [VL-1:0] exp_f = '0;
    logic [VL-1:0] exp_n = '0;
    string exp_tag = "R8";

    always #10 clk = ~clk;

    quad_msub_row #(.VL(VL), .WIDE_EN(1'b1)) i_quad_msub_row (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sz(in_sz), .in_row(in_row),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_acc(in_acc),
        .out_valid(f_valid), .out_undef(f_undef), .out_acc(f_acc)
    );

    quad_msub_row #(.VL(VL), .WIDE_EN(1'b0)) i_quad_msub_row_narrow (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sz(in_sz), .in_row(in_row),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_acc(in_acc),
        .out_valid(n_valid), .out_undef(n_undef), .out_acc(n_acc)
    );

    function automatic logic [VL-1:0] ref_row(input logic [VL-1:0] a, input logic [VL-1:0] b,
                                              input logic [VL-1:0] acc, input bit sz,
                                              input int row);
        int w  = sz ? 64 : 32;
        int nw = w / 4;
        logic [VL-1:0] r = acc;
        for (int e = 0; e < VL / w; e++) begin
            logic [63:0] x = '0;
            logic [63:0] y = '0;
            logic [63:0] c = '0;
            logic [63:0] d;
            for (int k = 0; k < nw; k++) begin
                x[k] = a[(4*e + row)*nw + k];
                y[k] = b[(4*e + row)*nw + k];
            end
            for (int k = 0; k < w; k++) c[k] = acc[e*w + k];
            d = c - x * y;
            for (int k = 0; k < w; k++) r[e*w + k] = d[k];
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [VL-1:0] act, input logic [VL-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_prev();
        check(f_valid == exp_v, "R5", "full valid", VL'(f_valid), VL'(exp_v));
        check(n_valid == exp_v, "R5", "narrow valid", VL'(n_valid), VL'(exp_v));
        check(f_undef == exp_fu, "R7", "full undef", VL'(f_undef), VL'(exp_fu));
        check(n_undef == exp_nu, "R6", "narrow undef", VL'(n_undef), VL'(exp_nu));
        if (exp_v || exp_tag == "R8") begin
            check(f_acc == exp_f, exp_tag, "full row", f_acc, exp_f);
            check(n_acc == exp_n, exp_nu ? "R6" : exp_tag, "narrow row", n_acc, exp_n);
        end
    endtask

    task automatic step(input bit v, input bit sz, input int row, input logic [VL-1:0] a,
                        input logic [VL-1:0] b, input logic [VL-1:0] acc, input string tag);
        @(negedge clk);
        check_prev();
        in_valid = v; in_sz = sz; in_row = 2'(row);
        in_src_a = a; in_src_b = b; in_acc = acc;
        exp_v = v;
        exp_fu = 1'b0;
        exp_nu = v && sz;
        exp_tag = tag;
        if (v) begin
            exp_f = ref_row(a, b, acc, sz, row);
            exp_n = sz ? acc : exp_f;
        end
    endtask

    function automatic logic [VL-1:0] rnd_vec();
        logic [VL-1:0] r;
        for (int k = 0; k < VL / 32; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [VL-1:0] ones;
        logic [VL-1:0] marked;
        int seed_set;
        ones = '1;
        seed_set = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check_prev(); // R8 reset state: all zero
        rst_n = 1'b1;
        // R3 wraparound: all-ones sources, zero accumulator, both sizes, every row
        for (int r = 0; r < 4; r++) begin
            step(1'b1, 1'b0, r, ones, ones, '0, "R3");
            step(1'b1, 1'b1, r, ones, ones, '0, "R3");
        end
        step(1'b0, 1'b0, 0, '0, '0, '0, "R5");
        // R2 element selection: one distinct byte per position, b = 1
        for (int k = 0; k < VL / 8; k++) marked[k*8 +: 8] = 8'(k + 1);
        for (int r = 0; r < 4; r++) begin
            step(1'b1, 1'b0, r, marked, {(VL/8){8'h01}}, ones, "R2");
            step(1'b1, 1'b1, r, marked, {(VL/16){16'h0001}}, ones, "R2");
            step(1'b0, 1'b1, r, '0, '0, '0, "R5");
        end
        // R4 every lane written: nonzero product in every lane
        step(1'b1, 1'b0, 1, ones, ones, {(VL/32){32'h1234_5678}}, "R4");
        step(1'b1, 1'b1, 2, ones, ones, {(VL/64){64'h0123_4567_89ab_cdef}}, "R4");
        step(1'b1, 1'b0, 3, ones, '0, ones, "R3");
        // R1 R6 R9 random back-to-back traffic
        for (int n = 0; n < 300; n++) begin
            bit v = ($urandom % 5) != 0;
            step(v, 1'($urandom), int'($urandom % 4), rnd_vec(), rnd_vec(), rnd_vec(),
                 v ? "R9" : "R5");
        end
        step(1'b0, 1'b0, 0, '0, '0, '0, "R5");
        step(1'b0, 1'b0, 0, '0, '0, '0, "R5");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule